// File: doc/BRIEF.md
# Software Write-Lock Command Detector

This block sits beside the page-write sequencer of a byte-alterable nonvolatile memory and decides, write by write, whether an accepted host write may reach the page buffer. It watches every write strobe, with its address and data, for two fixed command prefixes. The short prefix (three writes) arms a single page-load window and also turns the protection flag on. The long prefix (six writes) turns the protection flag off. While the flag is clear, every ordinary write is passed on. While it is set, ordinary writes are refused unless they fall inside an armed window. The window closes again once the sequencer reports that programming of the loaded page has finished.

The protection flag models nonvolatile state. The block reset clears the command tracker, the window and the output pulses, but leaves the flag alone. The flag takes its power-up value from a parameter. Command writes are consumed by the detector and never reach the page buffer. Each write that is refused raises a one-cycle rejection pulse for the status logic.

Top module: `swl_cmd_detect`

## Requirements
- R1: After `rst_n` is low, `wr_permit` and `wr_reject` are 0 and any partly received command is discarded. `lock_on` keeps its value through reset, and its power-up value is the parameter `INIT_LOCK` (default 0, unlocked).
- R2: While `lock_on` is 0 and no window is open, a write that is not part of a command produces `wr_permit`=1 and `wr_reject`=0 in the cycle after the strobe.
- R3: While `lock_on` is 1 and no window is open, a write that is not part of a command produces `wr_reject`=1 and `wr_permit`=0 in the cycle after the strobe.
- R4: The arm command is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. When it completes, `lock_on` is 1 from the next cycle, whatever its earlier value, and a page-load window opens. None of the command writes produces a permit or a reject pulse.
- R5: Inside an open window, the first `PAGE_BYTES` (default 64) writes each produce `wr_permit`. Any further write in the same window produces `wr_reject`.
- R6: A `prog_done` pulse closes an open window once at least one write has been permitted in it. A `prog_done` pulse that arrives before any such write leaves the window open.
- R7: The unlock command is six writes in this order: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. After it, `lock_on` is 0 from the next cycle.
- R8: A write that does not continue a partial command returns the tracker to idle and is handled as an ordinary write (R2/R3). A write of 0xAA at 0x5555 at any step restarts the command at its first step.
- R9: `wr_permit` and `wr_reject` are never both 1. Each pulse lasts one cycle and follows exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; does not touch the protection flag |
| wr_stb | input | 1 | One-cycle pulse marking an accepted host write |
| wr_addr | input | ADDR_W (15) | Address of the write |
| wr_data | input | DATA_W (8) | Data of the write |
| prog_done | input | 1 | Pulse from the write sequencer when programming ends |
| wr_permit | output | 1 | Write may be loaded into the page buffer |
| wr_reject | output | 1 | Write was refused |
| lock_on | output | 1 | Protection flag |

## Verification
The assertions assume that `wr_stb` is a single-cycle pulse per host write. They also assume that `prog_done` arrives only after the sequencer has started programming, and never in the same cycle as a write strobe. The bench keeps to these rules by driving every write and every `prog_done` as its own one-cycle pulse, with the two never overlapping. It separates windows with an explicit `prog_done` and applies its address/data sweeps only in states where a command prefix cannot form by accident.

// File: rtl/swl_pkg.sv
package swl_pkg;

   typedef enum logic [2:0] {
      STEP_IDLE,
      STEP_KEY1,
      STEP_KEY2,
      STEP_UNL1,
      STEP_UNL2,
      STEP_UNL3
   } swl_step_e;

endpackage

// File: rtl/swl_seq_match.sv
module swl_seq_match
   import swl_pkg::*;
#(
   parameter int                ADDR_W  = 15,
   parameter int                DATA_W  = 8,
   parameter logic [ADDR_W-1:0] ADR_A   = 'h5555,
   parameter logic [ADDR_W-1:0] ADR_B   = 'h2AAA,
   parameter logic [DATA_W-1:0] KEY1    = 'hAA,
   parameter logic [DATA_W-1:0] KEY2    = 'h55,
   parameter logic [DATA_W-1:0] ARM     = 'hA0,
   parameter logic [DATA_W-1:0] UNL_PRE = 'h80,
   parameter logic [DATA_W-1:0] UNL_FIN = 'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              bypass,
   output logic              is_cmd,
   output logic              arm_hit,
   output logic              unl_hit
);

   swl_step_e step_q, step_nx;
   logic      m_key1, m_key2, m_arm, m_pre, m_fin;
   logic      cmd_c, arm_c, unl_c;

   assign m_key1 = (addr == ADR_A) && (data == KEY1);
   assign m_key2 = (addr == ADR_B) && (data == KEY2);
   assign m_arm  = (addr == ADR_A) && (data == ARM);
   assign m_pre  = (addr == ADR_A) && (data == UNL_PRE);
   assign m_fin  = (addr == ADR_A) && (data == UNL_FIN);

   always_comb begin
      step_nx = STEP_IDLE;
      cmd_c   = 1'b0;
      arm_c   = 1'b0;
      unl_c   = 1'b0;
      unique case (step_q)
         STEP_IDLE: begin
            if (m_key1) begin step_nx = STEP_KEY1; cmd_c = 1'b1; end
         end
         STEP_KEY1: begin
            if (m_key2)      begin step_nx = STEP_KEY2; cmd_c = 1'b1; end
            else if (m_key1) begin step_nx = STEP_KEY1; cmd_c = 1'b1; end
         end
         STEP_KEY2: begin
            if (m_arm)       begin arm_c = 1'b1; cmd_c = 1'b1; end
            else if (m_pre)  begin step_nx = STEP_UNL1; cmd_c = 1'b1; end
            else if (m_key1) begin step_nx = STEP_KEY1; cmd_c = 1'b1; end
         end
         STEP_UNL1: begin
            if (m_key1) begin step_nx = STEP_UNL2; cmd_c = 1'b1; end
         end
         STEP_UNL2: begin
            if (m_key2)      begin step_nx = STEP_UNL3; cmd_c = 1'b1; end
            else if (m_key1) begin step_nx = STEP_KEY1; cmd_c = 1'b1; end
         end
         STEP_UNL3: begin
            if (m_fin)       begin unl_c = 1'b1; cmd_c = 1'b1; end
            else if (m_key1) begin step_nx = STEP_KEY1; cmd_c = 1'b1; end
         end
         default: step_nx = STEP_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           step_q <= STEP_IDLE;
      else if (bypass)      step_q <= STEP_IDLE;
      else if (stb)         step_q <= step_nx;
   end

   assign is_cmd  = stb && !bypass && cmd_c;
   assign arm_hit = stb && !bypass && arm_c;
   assign unl_hit = stb && !bypass && unl_c;

   AST_BREAK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !bypass && !is_cmd) |=> (step_q == STEP_IDLE)) else $error("break"); // R8
   AST_RESTART_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !bypass && m_key1 && step_q != STEP_UNL1) |=> (step_q == STEP_KEY1)) else $error("restart"); // R8

endmodule

// File: rtl/swl_window.sv
module swl_window #(
   parameter int PAGE_BYTES = 64,
   parameter bit LIMIT_PAGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_req,
   input  logic data_wr,
   input  logic prog_done,
   output logic win_open,
   output logic win_full
);

   localparam int CNT_W = $clog2(PAGE_BYTES + 1);

   logic win_any;

   if (PAGE_BYTES < 1) begin : g_bad_page
      $error("PAGE_BYTES must be at least 1");
   end

   if (LIMIT_PAGE) begin : g_limited
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                  cnt_q <= '0;
         else if (open_req)           cnt_q <= '0;
         else if (data_wr && !win_full) cnt_q <= cnt_q + 1'b1;
      end
      assign win_full = (cnt_q == CNT_W'(PAGE_BYTES));
      assign win_any  = (cnt_q != '0);

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CNT_W'(PAGE_BYTES)) else $error("count"); // R5
   end else begin : g_unlimited
      logic any_q;
      always_ff @(posedge clk) begin
         if (!rst_n)        any_q <= 1'b0;
         else if (open_req) any_q <= 1'b0;
         else if (data_wr)  any_q <= 1'b1;
      end
      assign win_full = 1'b0;
      assign win_any  = any_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    win_open <= 1'b0;
      else if (open_req)             win_open <= 1'b1;
      else if (prog_done && win_any) win_open <= 1'b0;
   end

   AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && prog_done && win_any && !open_req) |=> !win_open) else $error("relock"); // R6
   AST_EARLY_DONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && prog_done && !win_any && !data_wr) |=> win_open) else $error("early"); // R6

endmodule

// File: rtl/swl_cmd_detect.sv
module swl_cmd_detect #(
   parameter int                ADDR_W     = 15,
   parameter int                DATA_W     = 8,
   parameter int                PAGE_BYTES = 64,
   parameter bit                LIMIT_PAGE = 1'b1,
   parameter bit                INIT_LOCK  = 1'b0,
   parameter logic [ADDR_W-1:0] ADR_A      = 'h5555,
   parameter logic [ADDR_W-1:0] ADR_B      = 'h2AAA,
   parameter logic [DATA_W-1:0] KEY1       = 'hAA,
   parameter logic [DATA_W-1:0] KEY2       = 'h55,
   parameter logic [DATA_W-1:0] ARM        = 'hA0,
   parameter logic [DATA_W-1:0] UNL_PRE    = 'h80,
   parameter logic [DATA_W-1:0] UNL_FIN    = 'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              prog_done,
   output logic              wr_permit,
   output logic              wr_reject,
   output logic              lock_on
);

   if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_width
      $error("ADDR_W and DATA_W must be at least 2");
   end

   logic is_cmd, arm_hit, unl_hit;
   logic win_open, win_full, data_wr;
   logic arm_ok, unl_ok;
   logic lock_q = INIT_LOCK;
   logic permit_q, reject_q;

   swl_seq_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADR_A(ADR_A), .ADR_B(ADR_B),
      .KEY1(KEY1), .KEY2(KEY2), .ARM(ARM), .UNL_PRE(UNL_PRE), .UNL_FIN(UNL_FIN)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .stb(wr_stb), .addr(wr_addr), .data(wr_data),
      .bypass(win_open), .is_cmd(is_cmd), .arm_hit(arm_hit), .unl_hit(unl_hit)
   );

   assign arm_ok  = rst_n && arm_hit;
   assign unl_ok  = rst_n && unl_hit;
   assign data_wr = wr_stb && win_open && !win_full;

   swl_window #(.PAGE_BYTES(PAGE_BYTES), .LIMIT_PAGE(LIMIT_PAGE)) u_win (
      .clk(clk), .rst_n(rst_n), .open_req(arm_ok), .data_wr(data_wr),
      .prog_done(prog_done), .win_open(win_open), .win_full(win_full)
   );

   always_ff @(posedge clk) begin
      if (arm_ok)      lock_q <= 1'b1;
      else if (unl_ok) lock_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         permit_q <= 1'b0;
         reject_q <= 1'b0;
      end else if (win_open) begin
         permit_q <= wr_stb && !win_full;
         reject_q <= wr_stb && win_full;
      end else begin
         permit_q <= wr_stb && !is_cmd && !lock_q;
         reject_q <= wr_stb && !is_cmd && lock_q;
      end
   end

   assign wr_permit = permit_q;
   assign wr_reject = reject_q;
   assign lock_on   = lock_q;

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_permit && wr_reject)) else $error("excl"); // R9
   AST_PULSE_FROM_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_permit || wr_reject) |-> $past(wr_stb)) else $error("stb"); // R9
   AST_CMD_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
      is_cmd |=> (!wr_permit && !wr_reject)) else $error("cmd"); // R4
   AST_ARM_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      arm_hit |=> (lock_on && win_open)) else $error("arm"); // R4
   AST_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      unl_hit |=> !lock_on) else $error("unlock"); // R7
   AST_UNLOCKED_NO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !lock_on && !win_open) |=> !wr_reject) else $error("unl rej"); // R2

endmodule

// File: tb/swl_cmd_detect_test.sv
`timescale 1ns/100ps
module swl_cmd_detect_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [14:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        prog_done = 1'b0;
   logic        wr_permit, wr_reject, lock_on;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   swl_cmd_detect uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .prog_done(prog_done),
      .wr_permit(wr_permit), .wr_reject(wr_reject), .lock_on(lock_on)
   );

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [14:0] a, input logic [7:0] d,
                     input logic ep, input logic er, input string req);
      @(negedge clk);
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
      chk(req, wr_permit, ep, "permit");
      chk(req, wr_reject, er, "reject");
   endtask

   task automatic pulse_done();
      @(negedge clk);
      prog_done = 1'b1;
      @(negedge clk);
      prog_done = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic arm_seq(input string req);
      wr(15'h5555, 8'hAA, 1'b0, 1'b0, req);
      wr(15'h2AAA, 8'h55, 1'b0, 1'b0, req);
      wr(15'h5555, 8'hA0, 1'b0, 1'b0, req);
   endtask

   function automatic logic [14:0] unl_a(input int k);
      case (k)
         1, 4:    unl_a = 15'h2AAA;
         default: unl_a = 15'h5555;
      endcase
   endfunction

   function automatic logic [7:0] unl_d(input int k);
      case (k)
         0, 3:    unl_d = 8'hAA;
         1, 4:    unl_d = 8'h55;
         2:       unl_d = 8'h80;
         default: unl_d = 8'h20;
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state and power-up value of the flag
      chk("R1", wr_permit, 1'b0, "permit in reset");
      chk("R1", wr_reject, 1'b0, "reject in reset");
      chk("R1", lock_on, 1'b0, "power-up lock");
      rst_n = 1'b1;

      // R2: unlocked sweep of ordinary writes
      for (int i = 0; i < 300; i++) begin
         logic [14:0] a = 15'((i * 1237 + 3) & 32'h7FFF);
         logic [7:0]  d = 8'(i * 13);
         if (!(a == 15'h5555 && d == 8'hAA)) wr(a, d, 1'b1, 1'b0, "R2");
      end
      // R9: no pulse without a strobe
      @(negedge clk);
      chk("R9", wr_permit, 1'b0, "idle permit");
      chk("R9", wr_reject, 1'b0, "idle reject");

      // R4: arm from unlocked state
      arm_seq("R4");
      chk("R4", lock_on, 1'b1, "lock after arm");
      // R6: early prog_done leaves the window open
      pulse_done();
      wr(15'h0100, 8'h01, 1'b1, 1'b0, "R6");
      // R5: fill up to PAGE_BYTES, then refuse
      for (int i = 1; i < 64; i++) wr(15'(16'h0100 + i), 8'(i), 1'b1, 1'b0, "R5");
      wr(15'h0140, 8'h77, 1'b0, 1'b1, "R5");
      // R6: relock after programming
      pulse_done();
      wr(15'h0100, 8'h33, 1'b0, 1'b1, "R6");

      // R3: locked sweep
      for (int i = 0; i < 300; i++) begin
         logic [14:0] a = 15'((i * 2711 + 91) & 32'h7FFF);
         logic [7:0]  d = 8'(i * 29 + 1);
         if (!(a == 15'h5555 && d == 8'hAA)) wr(a, d, 1'b0, 1'b1, "R3");
      end

      // R8: break the unlock command after each prefix length
      for (int k = 1; k <= 5; k++) begin
         for (int j = 0; j < k; j++) wr(unl_a(j), unl_d(j), 1'b0, 1'b0, "R8");
         wr(15'h1234, 8'h11, 1'b0, 1'b1, "R8");
         wr(15'h5555, 8'hA0, 1'b0, 1'b1, "R8");
         chk("R8", lock_on, 1'b1, "lock after abort");
      end
      // R8: repeated first key restarts the command
      wr(15'h5555, 8'hAA, 1'b0, 1'b0, "R8");
      arm_seq("R8");
      wr(15'h0200, 8'h5A, 1'b1, 1'b0, "R8");
      pulse_done();

      // R1: reset keeps the flag and clears a partial command
      wr(15'h5555, 8'hAA, 1'b0, 1'b0, "R1");
      wr(15'h2AAA, 8'h55, 1'b0, 1'b0, "R1");
      do_reset();
      chk("R1", lock_on, 1'b1, "lock kept through reset");
      wr(15'h5555, 8'hA0, 1'b0, 1'b1, "R1");

      // R4: arm while already locked keeps the flag set
      arm_seq("R4");
      chk("R4", lock_on, 1'b1, "lock after rearm");
      wr(15'h0300, 8'hC3, 1'b1, 1'b0, "R4");
      pulse_done();

      // R7: unlock command
      for (int j = 0; j < 6; j++) wr(unl_a(j), unl_d(j), 1'b0, 1'b0, "R7");
      chk("R7", lock_on, 1'b0, "lock after unlock");
      wr(15'h0400, 8'h99, 1'b1, 1'b0, "R7");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule